// File: doc/BRIEF.md
# Byte-Interleaved Four-Bank Memory

This block is a 4 KB byte-addressable memory made of four 8-bit-wide banks. Consecutive byte addresses fall in consecutive banks. The two lowest address bits pick the bank, and the remaining upper bits give the row inside that bank. Because of this layout, an aligned 32-bit word occupies the same row in all four banks. A whole word can therefore be read or written in one access.

The requester presents four things in the same cycle:

- a byte address;
- one of three size strobes: byte, halfword or word;
- a read/not-write line;
- a global enable.

The block decodes one enable per bank from the size strobe and the low address bits. It steers byte lane k of the write bus into bank k. Read data returns on the cycle after the request, with bank k on byte lane k.

Misaligned halfword or word requests, and requests with more than one size strobe, raise an error flag. No bank is touched for such a request.

A small access-phase machine records what the previous cycle did. Its states are:

- `ST_IDLE`: nothing was enabled.
- `ST_READ`: a read was performed.
- `ST_WRITE`: a write was performed.
- `ST_FAULT`: an erroneous request was refused.

Each cycle the machine moves to the state that matches the current request, from any state:

- It goes to `ST_FAULT` when the global enable is high and the request is in error.
- It goes to `ST_READ` when the request is valid, enables at least one bank and is a read.
- It goes to `ST_WRITE` when the request is valid, enables at least one bank and is a write.
- It goes to `ST_IDLE` otherwise.

The read data bus is non-zero only in `ST_READ`.

Top module: `ilv_mem`

## Requirements
- R1: The bank is selected by address bits [1:0], and the row inside the bank is address bits [11:2]. Data written at a byte address reads back from that same byte address, including the highest word at 0xFFC.
- R2: An aligned word request (address bits [1:0] = 00) drives `bank_en` = 4'b1111.
- R3: An aligned halfword request drives `bank_en` = 4'b0011 when address bit 1 is 0, and 4'b1100 when it is 1.
- R4: A byte request drives a single bit of `bank_en`, at the position equal to address bits [1:0].
- R5: A halfword with address bit 0 set, or a word with address bits [1:0] not 00, sets `align_err` and clears all of `bank_en`. Memory contents are left unchanged.
- R6: More than one size strobe high together with `en` sets `align_err` and clears all of `bank_en`. No write occurs.
- R7: With `en` low, `bank_en` is 0 and `align_err` is 0, and no write occurs.
- R8: Read data appears on `rdata` one cycle after the read request. Bank k drives bits [8k+7:8k], and lanes of banks that were not enabled read as zero.
- R9: A write stores byte lane k of `wdata` into bank k only when `bank_en[k]` is set. All other bytes keep their value.
- R10: In the cycle after any request that is not an enabled, error-free read, `rdata` is zero.
- R11: After reset, `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 12 | Byte address |
| sz_byte | input | 1 | Byte size strobe |
| sz_half | input | 1 | Halfword size strobe |
| sz_word | input | 1 | Word size strobe |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| en | input | 1 | Global access enable |
| wdata | input | 32 | Write data, byte lane k feeds bank k |
| rdata | output | 32 | Read data, valid one cycle after a read |
| bank_en | output | 4 | Per-bank enables decoded this cycle |
| align_err | output | 1 | Misaligned or conflicting-size request |

## Verification
The bench builds the block with its default row width of 10 bits, which gives the full 4 KB space. At that size, both the lowest word at 0x000 and the highest word at 0xFFC are reachable, so the row field is exercised at both extremes. A byte-wide reference array in the bench tracks every write. This lets partial byte and halfword writes be checked against neighbouring bytes that must stay intact.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int SEL_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_FAULT
    } acc_st_t;
endpackage

// File: rtl/ilv_decode.sv
module ilv_decode
    import ilv_pkg::*;
(
    input  logic [SEL_W-1:0] lo,
    input  logic             sz_b,
    input  logic             sz_h,
    input  logic             sz_w,
    input  logic             en,
    output logic [LANES-1:0] sel,
    output logic             err
);
    logic multi;
    logic misal;
    logic ok;

    always_comb begin
        multi = (sz_b & sz_h) | (sz_b & sz_w) | (sz_h & sz_w);
        misal = (sz_h & lo[0]) | (sz_w & (lo != '0));
        err   = en & (multi | misal);
        ok    = en & ~multi & ~misal;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_sel
        localparam logic [SEL_W-1:0] KV = SEL_W'(k);
        assign sel[k] = ok & (sz_w
                            | (sz_h & (lo[1] == KV[1]))
                            | (sz_b & (lo == KV)));
    end
endmodule

// File: rtl/ilv_bank.sv
module ilv_bank #(
    parameter int IDX_W = 10,
    parameter int W     = 8
) (
    input  logic             clk,
    input  logic             cs,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [W-1:0]     d,
    output logic [W-1:0]     q
);
    localparam int DEPTH = 1 << IDX_W;

    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (cs) begin
            if (we) cells[idx] <= d;
            else    q          <= cells[idx];
        end
    end
endmodule

// File: rtl/ilv_mem.sv
module ilv_mem
    import ilv_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [IDX_W+SEL_W-1:0]    addr,
    input  logic                      sz_byte,
    input  logic                      sz_half,
    input  logic                      sz_word,
    input  logic                      rd_nwr,
    input  logic                      en,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output logic [LANES*LANE_W-1:0]   rdata,
    output logic [LANES-1:0]          bank_en,
    output logic                      align_err
);
    localparam int BUS_W = LANES * LANE_W;

    acc_st_t          st, st_nxt;
    logic [LANES-1:0] sel_q;
    logic [BUS_W-1:0] bank_q;
    logic [BUS_W-1:0] lane_mask;

    ilv_decode u_dec (
        .lo   (addr[SEL_W-1:0]),
        .sz_b (sz_byte),
        .sz_h (sz_half),
        .sz_w (sz_word),
        .en   (en),
        .sel  (bank_en),
        .err  (align_err)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_bank
        ilv_bank #(.IDX_W(IDX_W), .W(LANE_W)) u_bank (
            .clk (clk),
            .cs  (bank_en[k]),
            .we  (~rd_nwr),
            .idx (addr[IDX_W+SEL_W-1:SEL_W]),
            .d   (wdata[k*LANE_W +: LANE_W]),
            .q   (bank_q[k*LANE_W +: LANE_W])
        );
        assign lane_mask[k*LANE_W +: LANE_W] = {LANE_W{sel_q[k]}};
    end

    // next access phase
    always_comb begin
        if (!en)                 st_nxt = ST_IDLE;
        else if (align_err)      st_nxt = ST_FAULT;
        else if (bank_en == '0)  st_nxt = ST_IDLE;
        else if (rd_nwr)         st_nxt = ST_READ;
        else                     st_nxt = ST_WRITE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            sel_q <= '0;
        end else begin
            st    <= st_nxt;
            sel_q <= bank_en;
        end
    end

    // outputs
    always_comb begin
        unique case (st)
            ST_READ:  rdata = bank_q & lane_mask;
            ST_WRITE: rdata = '0;
            ST_FAULT: rdata = '0;
            ST_IDLE:  rdata = '0;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/ilv_mem_chk.sv
module ilv_mem_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [11:0] addr,
    input logic        sz_byte,
    input logic        sz_half,
    input logic        sz_word,
    input logic        rd_nwr,
    input logic        en,
    input logic [31:0] rdata,
    input logic [3:0]  bank_en,
    input logic        align_err
);
    logic only_b, only_h, only_w;
    assign only_b = sz_byte & ~sz_half & ~sz_word;
    assign only_h = sz_half & ~sz_byte & ~sz_word;
    assign only_w = sz_word & ~sz_byte & ~sz_half;

    p_word_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && only_w && addr[1:0] == 2'b00) |-> bank_en == 4'b1111);

    p_half_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && only_h && !addr[0]) |-> $countones(bank_en) == 2);

    p_byte_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && only_b) |-> bank_en == (4'b0001 << addr[1:0]));

    p_err_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> bank_en == 4'b0000);

    p_multi_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $countones({sz_byte, sz_half, sz_word}) > 1) |-> align_err);

    p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (bank_en == 4'b0000 && !align_err));

    p_lane_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_nwr && bank_en != 4'b0000) |=>
        (rdata & ~{{8{$past(bank_en[3])}}, {8{$past(bank_en[2])}},
                   {8{$past(bank_en[1])}}, {8{$past(bank_en[0])}}}) == 32'h0);

    p_noread_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_nwr && bank_en != 4'b0000) |=> rdata == 32'h0);
endmodule

bind ilv_mem ilv_mem_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .sz_byte   (sz_byte),
    .sz_half   (sz_half),
    .sz_word   (sz_word),
    .rd_nwr    (rd_nwr),
    .en        (en),
    .rdata     (rdata),
    .bank_en   (bank_en),
    .align_err (align_err)
);

// File: tb/ilv_mem_bench.sv
module ilv_mem_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        sz_byte = 1'b0, sz_half = 1'b0, sz_word = 1'b0;
    logic        rd_nwr = 1'b1, en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  bank_en;
    logic        align_err;

    int errors = 0;
    int checks = 0;
    logic [7:0] model [4096];

    always #2.5 clk = ~clk;

    ilv_mem u_ilv_mem (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .sz_byte(sz_byte), .sz_half(sz_half), .sz_word(sz_word),
        .rd_nwr(rd_nwr), .en(en), .wdata(wdata),
        .rdata(rdata), .bank_en(bank_en), .align_err(align_err)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [4:0] expect_dec(input logic [11:0] a, input logic b,
                                              input logic h, input logic w, input logic e);
        logic [3:0] s;
        logic       er;
        s  = 4'b0000;
        er = 1'b0;
        if (e) begin
            if ((b + h + w) > 1)              er = 1'b1;
            else if (h && a[0])               er = 1'b1;
            else if (w && a[1:0] != 2'b00)    er = 1'b1;
            else if (w)                       s = 4'b1111;
            else if (h)                       s = a[1] ? 4'b1100 : 4'b0011;
            else if (b)                       s = 4'b0001 << a[1:0];
        end
        return {er, s};
    endfunction

    task automatic op(input logic [11:0] a, input logic b, input logic h,
                      input logic w, input logic rd, input logic e,
                      input logic [31:0] wd, input string req);
        logic [4:0]  dx;
        logic [31:0] er;
        @(negedge clk);
        addr = a; sz_byte = b; sz_half = h; sz_word = w;
        rd_nwr = rd; en = e; wdata = wd;
        #1;
        dx = expect_dec(a, b, h, w, e);
        chk(req, "bank_en", {28'h0, bank_en}, {28'h0, dx[3:0]});
        chk(req, "align_err", {31'h0, align_err}, {31'h0, dx[4]});
        er = '0;
        if (rd && dx[3:0] != 4'b0000)
            for (int k = 0; k < 4; k++)
                if (dx[k]) er[8*k +: 8] = model[{a[11:2], 2'(k)}];
        @(posedge clk);
        #1;
        chk(req, "rdata", rdata, er);
        if (!rd)
            for (int k = 0; k < 4; k++)
                if (dx[k]) model[{a[11:2], 2'(k)}] = wd[8*k +: 8];
        en = 1'b0; sz_byte = 1'b0; sz_half = 1'b0; sz_word = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R11", "rdata after reset", rdata, 32'h0);
    endtask

    task automatic t_word;
        op(12'h100, 0, 0, 1, 0, 1, 32'hA1B2C3D4, "R2");
        op(12'h100, 0, 0, 1, 1, 1, 32'h0, "R2");
        op(12'hFFC, 0, 0, 1, 0, 1, 32'h0BADF00D, "R1");
        op(12'hFFC, 0, 0, 1, 1, 1, 32'h0, "R1");
        op(12'h000, 0, 0, 1, 0, 1, 32'h11223344, "R1");
        op(12'h000, 0, 0, 1, 1, 1, 32'h0, "R1");
    endtask

    task automatic t_byte;
        op(12'h200, 0, 0, 1, 0, 1, 32'h0, "R9");
        op(12'h201, 1, 0, 0, 0, 1, 32'h1234EE56, "R4");
        op(12'h203, 1, 0, 0, 0, 1, 32'h77AABBCC, "R4");
        op(12'h200, 0, 0, 1, 1, 1, 32'h0, "R9");
        op(12'h203, 1, 0, 0, 1, 1, 32'h0, "R8");
        op(12'h202, 1, 0, 0, 1, 1, 32'h0, "R8");
        op(12'h101, 1, 0, 0, 1, 1, 32'h0, "R1");
    endtask

    task automatic t_half;
        op(12'h300, 0, 0, 1, 0, 1, 32'hDEADBEEF, "R3");
        op(12'h302, 0, 1, 0, 0, 1, 32'h55667788, "R3");
        op(12'h300, 0, 0, 1, 1, 1, 32'h0, "R9");
        op(12'h300, 0, 1, 0, 1, 1, 32'h0, "R8");
        op(12'h302, 0, 1, 0, 1, 1, 32'h0, "R3");
    endtask

    task automatic t_misalign;
        op(12'h301, 0, 1, 0, 0, 1, 32'hFFFFFFFF, "R5");
        op(12'h302, 0, 0, 1, 0, 1, 32'hFFFFFFFF, "R5");
        op(12'h301, 0, 0, 1, 0, 1, 32'hFFFFFFFF, "R5");
        op(12'h303, 0, 1, 0, 1, 1, 32'h0, "R10");
        op(12'h300, 0, 0, 1, 1, 1, 32'h0, "R5");
    endtask

    task automatic t_multi;
        op(12'h300, 1, 0, 1, 0, 1, 32'h01010101, "R6");
        op(12'h300, 0, 1, 1, 0, 1, 32'h02020202, "R6");
        op(12'h300, 1, 1, 0, 1, 1, 32'h0, "R6");
        op(12'h300, 0, 0, 1, 1, 1, 32'h0, "R6");
    endtask

    task automatic t_disable;
        op(12'h300, 0, 0, 1, 0, 0, 32'h99999999, "R7");
        op(12'h300, 0, 0, 1, 1, 0, 32'h0, "R7");
        op(12'h300, 0, 0, 1, 1, 1, 32'h0, "R7");
        op(12'h100, 0, 0, 1, 0, 1, 32'h13579BDF, "R10");
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) model[i] = 8'h00;
        t_reset;
        t_word;
        t_byte;
        t_half;
        t_misalign;
        t_multi;
        t_disable;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule